// File: doc/BRIEF.md
# Power Management Event Controller

This block gathers platform power events into status latches, masks them with a software-written enable register, and drives a level-sensitive system control interrupt (`sci`). Software reaches the status, enable and control registers and a timer readback through an I/O window. Configuration byte writes set the window's base and switch decoding on or off. A small general-purpose event bank adds one more interrupt source.

An advanced-power-management command byte turns the ACPI-mode bit in the control register on or off. When a configuration bit allows it, every such command also produces a one-cycle system-management interrupt (`smi`). A free-running timer sets a status bit each time its most significant bit changes. Power-button, real-time-clock alarm and global-lock release requests set their own status bits.

Top module: `pm_event_ctrl`

## Requirements
- R1: After reset, every status, enable, control and general-purpose register is zero, the timer is zero, `sci` and `smi` are low, the window is disabled and its base is 0x0000.
- R2: The window is decoded only while bit 0 of configuration byte 0x80 is 1. A hit requires `io_addr[15:6]` to equal bits 15:6 of the base, which is configuration byte 0x41 (high) concatenated with byte 0x40 (low), masked with 0xFFC0. Without a hit, `io_rdata` is 0 and writes change nothing.
- R3: Inside the window, offset 0x00 is event status and 0x02 is event enable. Offset 0x04 is control and 0x08 is the timer, zero-extended to 32 bits. Any other offset reads 0 and ignores writes.
- R4: Only status bits 0 (timer), 5 (global lock), 8 (power button) and 10 (RTC alarm) exist; the others read 0. Writing a 1 to one of these bits clears it. If a set event and a clearing write reach the same bit in the same cycle, the bit ends up set.
- R5: After each clock edge, `sci` equals 1 exactly when (status AND enable) has bit 0, 5, 8 or 10 set, or when bit 1 is set in both general-purpose status and general-purpose enable.
- R6: Each bit of `gpe_set` sets the matching general-purpose status bit. A `gpe_wr_en` with `gpe_sel`=0 clears the status bits written as 1. With `gpe_sel`=1 it loads the general-purpose enable. `gpe_rdata` shows enable when `gpe_sel`=1 and status when `gpe_sel`=0.
- R7: The timer increments on every clock. Status bit 0 is set on the edge where the timer's most significant bit changes.
- R8: A `pwrbtn_req` pulse sets status bit 8. `rtc_alarm` sets bit 10 and `glk_req` sets bit 5.
- R9: A write to control stores all 16 bits. An APM command 0xF1 sets control bit 0 and 0xF0 clears it. Any other command leaves control unchanged. The APM command takes precedence over a control write in the same cycle.
- R10: `smi` is high for the single cycle after an APM command write, and only if bit 1 of configuration byte 0x5B was 1 when the command was written. Otherwise it stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr_en | input | 1 | Configuration byte write strobe |
| cfg_addr | input | 8 | Configuration byte offset |
| cfg_wdata | input | 8 | Configuration byte data |
| io_addr | input | 16 | I/O address for register reads and writes |
| io_wr_en | input | 1 | I/O write strobe |
| io_wdata | input | 16 | I/O write data |
| io_rdata | output | 32 | Read data for `io_addr`, combinational |
| gpe_wr_en | input | 1 | General-purpose register write strobe |
| gpe_sel | input | 1 | 0 selects GP status, 1 selects GP enable |
| gpe_wdata | input | GPE_W | General-purpose write data |
| gpe_set | input | GPE_W | General-purpose event set pulses |
| gpe_rdata | output | GPE_W | Selected general-purpose register |
| pwrbtn_req | input | 1 | Power-button event pulse |
| rtc_alarm | input | 1 | RTC alarm event pulse |
| glk_req | input | 1 | Global-lock release event pulse |
| apm_wr_en | input | 1 | APM command write strobe |
| apm_cmd | input | 8 | APM command byte |
| sci | output | 1 | Level system control interrupt |
| smi | output | 1 | One-cycle system management interrupt |

## Verification
The interrupt combination is driven separately by each event source, with its enable bit both on and off. One pattern sets general-purpose bit 0 while only enable bit 0 is on. This shows that only bit 1 of the general-purpose bank reaches `sci` and that matching bits in other positions are ignored. Window decode is tested with the window disabled, at unmapped offsets, one byte past the window, and after the window is relocated; these separate base comparison from offset decode. Two further patterns, a set and a clear on the same status bit in one cycle, and an APM command in the same cycle as a control write, check the stated precedence.

// File: rtl/pm_evt_pkg.sv
package pm_evt_pkg;
   localparam int unsigned STS_TMR = 0;
   localparam int unsigned STS_GLK = 5;
   localparam int unsigned STS_PWR = 8;
   localparam int unsigned STS_RTC = 10;
   localparam logic [15:0] STS_IMPL = 16'h0521;

   localparam int unsigned CTL_SCI_EN  = 0;
   localparam int unsigned GPE_SCI_BIT = 1;

   localparam logic [7:0] APM_ACPI_ON  = 8'hF1;
   localparam logic [7:0] APM_ACPI_OFF = 8'hF0;

   localparam logic [7:0] CFG_BASE_LO = 8'h40;
   localparam logic [7:0] CFG_BASE_HI = 8'h41;
   localparam logic [7:0] CFG_SMI_CTL = 8'h5B;
   localparam logic [7:0] CFG_WIN_CTL = 8'h80;

   localparam int unsigned OFS_STS = 'h00;
   localparam int unsigned OFS_EN  = 'h02;
   localparam int unsigned OFS_CTL = 'h04;
   localparam int unsigned OFS_TMR = 'h08;

   typedef enum logic [2:0] {
      SEL_NONE,
      SEL_STS,
      SEL_EN,
      SEL_CTL,
      SEL_TMR
   } pm_sel_e;
endpackage

// File: rtl/pm_cfg_space.sv
module pm_cfg_space #(
   parameter int unsigned WIN_AW = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_wr_en,
   input  logic [7:0]        cfg_addr,
   input  logic [7:0]        cfg_wdata,
   output logic [15:WIN_AW]  win_base,
   output logic              win_en,
   output logic              smi_en
);
   import pm_evt_pkg::*;

   logic [15:WIN_AW] base_q;
   logic             win_q;
   logic             smi_q;

   // Low byte bit 0 is hard-wired to 1 and sits below the decoded bits,
   // so only the upper address bits are kept.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         base_q <= '0;
         win_q  <= 1'b0;
         smi_q  <= 1'b0;
      end else if (cfg_wr_en) begin
         case (cfg_addr)
            CFG_BASE_LO: base_q[7:WIN_AW] <= cfg_wdata[7:WIN_AW];
            CFG_BASE_HI: base_q[15:8]     <= cfg_wdata;
            CFG_WIN_CTL: win_q            <= cfg_wdata[0];
            CFG_SMI_CTL: smi_q            <= cfg_wdata[1];
            default: ;
         endcase
      end
   end

   assign win_base = base_q;
   assign win_en   = win_q;
   assign smi_en   = smi_q;
endmodule

// File: rtl/pm_win_decode.sv
module pm_win_decode #(
   parameter int unsigned WIN_AW = 6
) (
   input  logic [15:0]          io_addr,
   input  logic [15:WIN_AW]     win_base,
   input  logic                 win_en,
   output pm_evt_pkg::pm_sel_e  sel
);
   import pm_evt_pkg::*;

   logic              hit;
   logic [WIN_AW-1:0] ofs;

   assign hit = win_en && (io_addr[15:WIN_AW] == win_base);
   assign ofs = io_addr[WIN_AW-1:0];

   always_comb begin
      sel = SEL_NONE;
      if (hit) begin
         if (ofs == WIN_AW'(OFS_STS))      sel = SEL_STS;
         else if (ofs == WIN_AW'(OFS_EN))  sel = SEL_EN;
         else if (ofs == WIN_AW'(OFS_CTL)) sel = SEL_CTL;
         else if (ofs == WIN_AW'(OFS_TMR)) sel = SEL_TMR;
      end
   end
endmodule

// File: rtl/pm_timer.sv
module pm_timer #(
   parameter int unsigned TMR_W = 24
) (
   input  logic             clk,
   input  logic             rst_n,
   output logic [TMR_W-1:0] cnt,
   output logic             tick
);
   logic [TMR_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cnt_q <= '0;
      else        cnt_q <= cnt_q + 1'b1;
   end

   // The top bit changes on the increment from an all-ones lower part.
   assign tick = &cnt_q[TMR_W-2:0];
   assign cnt  = cnt_q;
endmodule

// File: rtl/pm_evt_regs.sv
module pm_evt_regs #(
   parameter int unsigned GPE_W          = 8,
   parameter bit          SCI_REGISTERED = 1'b1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  pm_evt_pkg::pm_sel_e sel,
   input  logic                io_wr_en,
   input  logic [15:0]         io_wdata,
   input  logic                tmr_tick,
   input  logic                pwrbtn_req,
   input  logic                rtc_alarm,
   input  logic                glk_req,
   input  logic                gpe_wr_en,
   input  logic                gpe_sel,
   input  logic [GPE_W-1:0]    gpe_wdata,
   input  logic [GPE_W-1:0]    gpe_set,
   input  logic                apm_wr_en,
   input  logic [7:0]          apm_cmd,
   input  logic                smi_en,
   output logic [15:0]         sts,
   output logic [15:0]         en,
   output logic [15:0]         ctl,
   output logic [GPE_W-1:0]    gsts,
   output logic [GPE_W-1:0]    gen,
   output logic                sci,
   output logic                smi
);
   import pm_evt_pkg::*;

   logic [15:0]      sts_q, sts_d, en_q, en_d, ctl_q, ctl_d;
   logic [GPE_W-1:0] gsts_q, gsts_d, gen_q, gen_d;
   logic [15:0]      sts_clr, sts_set;
   logic [GPE_W-1:0] gsts_clr;
   logic             smi_q;

   function automatic logic sci_of(input logic [15:0] s, input logic [15:0] e,
                                   input logic [GPE_W-1:0] gs,
                                   input logic [GPE_W-1:0] ge);
      return (|(s & e & STS_IMPL)) || (gs[GPE_SCI_BIT] && ge[GPE_SCI_BIT]);
   endfunction

   always_comb begin
      sts_clr = (io_wr_en && sel == SEL_STS) ? io_wdata : 16'h0000;
      sts_set = '0;
      sts_set[STS_TMR] = tmr_tick;
      sts_set[STS_GLK] = glk_req;
      sts_set[STS_PWR] = pwrbtn_req;
      sts_set[STS_RTC] = rtc_alarm;
      sts_d = ((sts_q & ~sts_clr) | sts_set) & STS_IMPL;

      en_d = (io_wr_en && sel == SEL_EN) ? io_wdata : en_q;

      ctl_d = (io_wr_en && sel == SEL_CTL) ? io_wdata : ctl_q;
      if (apm_wr_en) begin
         if (apm_cmd == APM_ACPI_ON)       ctl_d[CTL_SCI_EN] = 1'b1;
         else if (apm_cmd == APM_ACPI_OFF) ctl_d[CTL_SCI_EN] = 1'b0;
      end

      gsts_clr = (gpe_wr_en && !gpe_sel) ? gpe_wdata : '0;
      gsts_d   = (gsts_q & ~gsts_clr) | gpe_set;
      gen_d    = (gpe_wr_en && gpe_sel) ? gpe_wdata : gen_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sts_q  <= '0;
         en_q   <= '0;
         ctl_q  <= '0;
         gsts_q <= '0;
         gen_q  <= '0;
         smi_q  <= 1'b0;
      end else begin
         sts_q  <= sts_d;
         en_q   <= en_d;
         ctl_q  <= ctl_d;
         gsts_q <= gsts_d;
         gen_q  <= gen_d;
         smi_q  <= apm_wr_en && smi_en;
      end
   end

   generate
      if (SCI_REGISTERED) begin : g_sci_reg
         logic sci_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sci_q <= 1'b0;
            else        sci_q <= sci_of(sts_d, en_d, gsts_d, gen_d);
         end
         assign sci = sci_q;
      end else begin : g_sci_comb
         assign sci = sci_of(sts_q, en_q, gsts_q, gen_q);
      end
   endgenerate

   assign sts  = sts_q;
   assign en   = en_q;
   assign ctl  = ctl_q;
   assign gsts = gsts_q;
   assign gen  = gen_q;
   assign smi  = smi_q;

   assert_w1c_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (io_wr_en && sel == SEL_STS && io_wdata[STS_PWR] && !pwrbtn_req) |=> !sts_q[STS_PWR])
      else $error("status bit not cleared by write-one");
   assert_timer_sets_R7: assert property (@(posedge clk) disable iff (!rst_n)
      tmr_tick |=> sts_q[STS_TMR])
      else $error("timer status not set on top-bit change");
   assert_pwrbtn_sets_R8: assert property (@(posedge clk) disable iff (!rst_n)
      pwrbtn_req |=> sts_q[STS_PWR])
      else $error("power button status not set");
   assert_apm_on_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (apm_wr_en && apm_cmd == APM_ACPI_ON) |=> ctl_q[CTL_SCI_EN])
      else $error("ACPI mode bit not set by command");
   assert_apm_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (apm_wr_en && apm_cmd == APM_ACPI_OFF) |=> !ctl_q[CTL_SCI_EN])
      else $error("ACPI mode bit not cleared by command");
   assert_smi_cause_R10: assert property (@(posedge clk) disable iff (!rst_n)
      smi_q |-> $past(apm_wr_en && smi_en))
      else $error("smi without an enabled command");
endmodule

// File: rtl/pm_event_ctrl.sv
module pm_event_ctrl #(
   parameter int unsigned TMR_W          = 24,
   parameter int unsigned GPE_W          = 8,
   parameter int unsigned WIN_BYTES      = 64,
   parameter bit          SCI_REGISTERED = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cfg_wr_en,
   input  logic [7:0]       cfg_addr,
   input  logic [7:0]       cfg_wdata,
   input  logic [15:0]      io_addr,
   input  logic             io_wr_en,
   input  logic [15:0]      io_wdata,
   output logic [31:0]      io_rdata,
   input  logic             gpe_wr_en,
   input  logic             gpe_sel,
   input  logic [GPE_W-1:0] gpe_wdata,
   input  logic [GPE_W-1:0] gpe_set,
   output logic [GPE_W-1:0] gpe_rdata,
   input  logic             pwrbtn_req,
   input  logic             rtc_alarm,
   input  logic             glk_req,
   input  logic             apm_wr_en,
   input  logic [7:0]       apm_cmd,
   output logic             sci,
   output logic             smi
);
   import pm_evt_pkg::*;

   localparam int unsigned WIN_AW = $clog2(WIN_BYTES);

   generate
      if (TMR_W < 2 || TMR_W > 32) begin : g_bad_tmr
         $error("TMR_W must lie in 2..32");
      end
      if (GPE_W <= GPE_SCI_BIT) begin : g_bad_gpe
         $error("GPE_W too small for the interrupt-routed bit");
      end
      if (WIN_BYTES != (1 << WIN_AW) || WIN_AW < 4 || WIN_AW > 7) begin : g_bad_win
         $error("WIN_BYTES must be a power of two in 16..128");
      end
   endgenerate

   logic [15:WIN_AW] win_base;
   logic             win_en, smi_en, tmr_tick;
   logic [TMR_W-1:0] tmr_cnt;
   pm_sel_e          sel;
   logic [15:0]      sts, en, ctl;
   logic [GPE_W-1:0] gsts, gen;

   pm_cfg_space #(.WIN_AW(WIN_AW)) u_cfg (
      .clk(clk), .rst_n(rst_n), .cfg_wr_en(cfg_wr_en), .cfg_addr(cfg_addr),
      .cfg_wdata(cfg_wdata), .win_base(win_base), .win_en(win_en), .smi_en(smi_en)
   );

   pm_win_decode #(.WIN_AW(WIN_AW)) u_dec (
      .io_addr(io_addr), .win_base(win_base), .win_en(win_en), .sel(sel)
   );

   pm_timer #(.TMR_W(TMR_W)) u_tmr (
      .clk(clk), .rst_n(rst_n), .cnt(tmr_cnt), .tick(tmr_tick)
   );

   pm_evt_regs #(.GPE_W(GPE_W), .SCI_REGISTERED(SCI_REGISTERED)) u_regs (
      .clk(clk), .rst_n(rst_n), .sel(sel), .io_wr_en(io_wr_en), .io_wdata(io_wdata),
      .tmr_tick(tmr_tick), .pwrbtn_req(pwrbtn_req), .rtc_alarm(rtc_alarm),
      .glk_req(glk_req), .gpe_wr_en(gpe_wr_en), .gpe_sel(gpe_sel),
      .gpe_wdata(gpe_wdata), .gpe_set(gpe_set), .apm_wr_en(apm_wr_en),
      .apm_cmd(apm_cmd), .smi_en(smi_en), .sts(sts), .en(en), .ctl(ctl),
      .gsts(gsts), .gen(gen), .sci(sci), .smi(smi)
   );

   always_comb begin
      case (sel)
         SEL_STS: io_rdata = {16'h0000, sts};
         SEL_EN:  io_rdata = {16'h0000, en};
         SEL_CTL: io_rdata = {16'h0000, ctl};
         SEL_TMR: io_rdata = 32'(tmr_cnt);
         default: io_rdata = 32'h0;
      endcase
   end

   assign gpe_rdata = gpe_sel ? gen : gsts;

   assert_sci_source_R5: assert property (@(posedge clk) disable iff (!rst_n)
      sci |-> (((sts & en) != 16'h0) || ((gsts & gen) != '0)))
      else $error("sci high with no enabled event");
endmodule

// File: tb/tb_pm_event_ctrl.sv
`timescale 1ns/1ps
module tb_pm_event_ctrl;
   localparam int TW = 8;
   localparam int GW = 8;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          cfg_wr_en = 1'b0;
   logic [7:0]    cfg_addr = '0, cfg_wdata = '0;
   logic [15:0]   io_addr = '0, io_wdata = '0;
   logic          io_wr_en = 1'b0;
   logic [31:0]   io_rdata;
   logic          gpe_wr_en = 1'b0, gpe_sel = 1'b0;
   logic [GW-1:0] gpe_wdata = '0, gpe_set = '0, gpe_rdata;
   logic          pwrbtn_req = 1'b0, rtc_alarm = 1'b0, glk_req = 1'b0;
   logic          apm_wr_en = 1'b0;
   logic [7:0]    apm_cmd = '0;
   logic          sci, smi;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   pm_event_ctrl #(.TMR_W(TW), .GPE_W(GW)) dut (
      .clk(clk), .rst_n(rst_n), .cfg_wr_en(cfg_wr_en), .cfg_addr(cfg_addr),
      .cfg_wdata(cfg_wdata), .io_addr(io_addr), .io_wr_en(io_wr_en),
      .io_wdata(io_wdata), .io_rdata(io_rdata), .gpe_wr_en(gpe_wr_en),
      .gpe_sel(gpe_sel), .gpe_wdata(gpe_wdata), .gpe_set(gpe_set),
      .gpe_rdata(gpe_rdata), .pwrbtn_req(pwrbtn_req), .rtc_alarm(rtc_alarm),
      .glk_req(glk_req), .apm_wr_en(apm_wr_en), .apm_cmd(apm_cmd),
      .sci(sci), .smi(smi)
   );

   // behavioural reference model
   logic [15:0]   m_sts = 0, m_en = 0, m_ctl = 0, m_base = 16'h0001, n_sts;
   logic [GW-1:0] m_gsts = 0, m_gen = 0;
   logic [7:0]    m_c5b = 0;
   logic          m_win = 0, m_smi = 0, m_sci = 0, m_hit, m_tick;
   logic [TW-1:0] m_cnt = 0;

   function automatic logic [31:0] m_read(input logic [15:0] a);
      if (!m_win || a[15:6] != m_base[15:6]) return 32'h0;
      case (a[5:0])
         6'h00:   return {16'h0, m_sts};
         6'h02:   return {16'h0, m_en};
         6'h04:   return {16'h0, m_ctl};
         6'h08:   return 32'(m_cnt);
         default: return 32'h0;
      endcase
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         m_sts = 0; m_en = 0; m_ctl = 0; m_base = 16'h0001; m_gsts = 0; m_gen = 0;
         m_c5b = 0; m_win = 0; m_smi = 0; m_sci = 0; m_cnt = 0;
      end else begin
         m_hit  = m_win && (io_addr[15:6] == m_base[15:6]);
         m_tick = (m_cnt[TW-2:0] == {(TW-1){1'b1}});
         n_sts  = m_sts;
         if (io_wr_en && m_hit && io_addr[5:0] == 6'h00) n_sts = n_sts & ~io_wdata;
         if (m_tick)     n_sts[0]  = 1'b1;
         if (glk_req)    n_sts[5]  = 1'b1;
         if (pwrbtn_req) n_sts[8]  = 1'b1;
         if (rtc_alarm)  n_sts[10] = 1'b1;
         m_sts = n_sts & 16'h0521;
         if (io_wr_en && m_hit && io_addr[5:0] == 6'h02) m_en = io_wdata;
         if (io_wr_en && m_hit && io_addr[5:0] == 6'h04) m_ctl = io_wdata;
         if (apm_wr_en && apm_cmd == 8'hF1) m_ctl[0] = 1'b1;
         if (apm_wr_en && apm_cmd == 8'hF0) m_ctl[0] = 1'b0;
         if (gpe_wr_en && !gpe_sel) m_gsts = m_gsts & ~gpe_wdata;
         m_gsts = m_gsts | gpe_set;
         if (gpe_wr_en && gpe_sel) m_gen = gpe_wdata;
         m_smi = apm_wr_en && m_c5b[1];
         if (cfg_wr_en) begin
            if (cfg_addr == 8'h40) m_base[7:0]  = cfg_wdata | 8'h01;
            if (cfg_addr == 8'h41) m_base[15:8] = cfg_wdata;
            if (cfg_addr == 8'h80) m_win        = cfg_wdata[0];
            if (cfg_addr == 8'h5B) m_c5b        = cfg_wdata;
         end
         m_cnt = m_cnt + 1'b1;
         m_sci = ((m_sts & m_en & 16'h0521) != 0) || (m_gsts[1] && m_gen[1]);
      end
   end

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // per-cycle comparison against the model
   always @(negedge clk) begin
      if (rst_n && !done) begin
         chk("R5 sci", 32'(sci), 32'(m_sci));
         chk("R10 smi", 32'(smi), 32'(m_smi));
         chk("R3 io_rdata", io_rdata, m_read(io_addr));
         chk("R6 gpe_rdata", 32'(gpe_rdata), 32'(gpe_sel ? m_gen : m_gsts));
      end
   end

   task automatic step(); @(posedge clk); #1; endtask
   task automatic cfg_wr(input logic [7:0] a, input logic [7:0] d);
      cfg_addr = a; cfg_wdata = d; cfg_wr_en = 1; step(); cfg_wr_en = 0;
   endtask
   task automatic io_wr(input logic [15:0] a, input logic [15:0] d);
      io_addr = a; io_wdata = d; io_wr_en = 1; step(); io_wr_en = 0;
   endtask
   task automatic gpe_wr(input logic s, input logic [GW-1:0] d);
      gpe_sel = s; gpe_wdata = d; gpe_wr_en = 1; step(); gpe_wr_en = 0;
   endtask
   task automatic apm(input logic [7:0] c);
      apm_cmd = c; apm_wr_en = 1; step(); apm_wr_en = 0;
   endtask
   task automatic rd_chk(input string req, input logic [15:0] a,
                         input logic [31:0] mask, input logic [31:0] exp);
      io_addr = a; #1;
      chk(req, io_rdata & mask, exp);
   endtask

   initial begin
      repeat (2000) begin
         @(posedge clk);
         if (done) break;
      end
      if (!done) begin
         errors++;
         $display("FAIL watchdog expired");
         $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      logic [31:0] t1;
      int waited;
      repeat (4) @(posedge clk);
      #1 rst_n = 1;
      // R1: reset state, window off
      rd_chk("R1 window off", 16'h0000, 32'hFFFFFFFF, 0);
      chk("R1 sci", 32'(sci), 0);
      chk("R1 smi", 32'(smi), 0);
      chk("R1 gpe", 32'(gpe_rdata), 0);
      cfg_wr(8'h40, 8'h80);
      cfg_wr(8'h41, 8'hA5);
      // R2: window disabled, write must not land
      io_wr(16'hA582, 16'hFFFF);
      cfg_wr(8'h80, 8'h01);
      rd_chk("R2 write ignored while off", 16'hA582, 32'hFFFFFFFF, 0);
      io_wr(16'hA582, 16'h0520);
      rd_chk("R3 enable", 16'hA582, 32'hFFFFFFFF, 32'h0520);
      rd_chk("R1 control zero", 16'hA584, 32'hFFFFFFFF, 0);
      // R7: timer advances by one per cycle
      rd_chk("R7 timer", 16'hA588, 32'hFFFFFF00, 0);
      t1 = io_rdata; step();
      rd_chk("R7 timer step", 16'hA588, 32'hFFFFFFFF, (t1 + 1) & 32'hFF);
      // R8 power button, R4 clear
      pwrbtn_req = 1; step(); pwrbtn_req = 0;
      rd_chk("R8 pwr status", 16'hA580, 32'hFFFE, 32'h0100);
      chk("R8 sci", 32'(sci), 1);
      io_wr(16'hA580, 16'h0100);
      rd_chk("R4 w1c", 16'hA580, 32'hFFFE, 0);
      chk("R4 sci low", 32'(sci), 0);
      // R4: set wins over clear in the same cycle
      pwrbtn_req = 1; io_wr(16'hA580, 16'h0100); pwrbtn_req = 0;
      rd_chk("R4 set wins", 16'hA580, 32'hFFFE, 32'h0100);
      io_wr(16'hA580, 16'hFFFE);
      rd_chk("R4 unimplemented bits", 16'hA580, 32'hFFFE, 0);
      rtc_alarm = 1; step(); rtc_alarm = 0;
      chk("R8 rtc sci", 32'(sci), 1);
      io_wr(16'hA580, 16'h0400);
      glk_req = 1; step(); glk_req = 0;
      chk("R8 glk sci", 32'(sci), 1);
      io_wr(16'hA580, 16'h0020);
      // R5: masked source keeps sci low
      io_wr(16'hA582, 16'h0000);
      rtc_alarm = 1; step(); rtc_alarm = 0;
      chk("R5 masked", 32'(sci), 0);
      rd_chk("R5 status kept", 16'hA580, 32'hFFFE, 32'h0400);
      io_wr(16'hA580, 16'h0400);
      // R3 unmapped offsets, R2 outside window
      io_wr(16'hA586, 16'h1234);
      rd_chk("R3 offset 06", 16'hA586, 32'hFFFFFFFF, 0);
      rd_chk("R3 offset 3E", 16'hA5BE, 32'hFFFFFFFF, 0);
      rd_chk("R2 past window", 16'hA5C0, 32'hFFFFFFFF, 0);
      // R9 control
      io_wr(16'hA584, 16'h2400);
      rd_chk("R9 control store", 16'hA584, 32'hFFFFFFFF, 32'h2400);
      // R6 GPE
      gpe_set = 8'h01; step(); gpe_set = 0;
      gpe_wr(1'b1, 8'h01);
      chk("R5 gpe bit0 ignored", 32'(sci), 0);
      gpe_wr(1'b1, 8'h02);
      gpe_set = 8'h02; step(); gpe_set = 0;
      chk("R5 gpe bit1", 32'(sci), 1);
      chk("R6 enable read", 32'(gpe_rdata), 32'h02);
      gpe_sel = 0; #1;
      chk("R6 status read", 32'(gpe_rdata), 32'h03);
      gpe_wr(1'b0, 8'h02);
      chk("R6 w1c", 32'(gpe_rdata), 32'h01);
      chk("R6 sci low", 32'(sci), 0);
      // R9 APM, R10 SMI gating
      apm(8'hF1);
      rd_chk("R9 F1", 16'hA584, 32'hFFFFFFFF, 32'h2401);
      chk("R10 smi gated", 32'(smi), 0);
      apm(8'h55);
      rd_chk("R9 other cmd", 16'hA584, 32'hFFFFFFFF, 32'h2401);
      apm(8'hF0);
      rd_chk("R9 F0", 16'hA584, 32'hFFFFFFFF, 32'h2400);
      apm_cmd = 8'hF1; apm_wr_en = 1; io_wr(16'hA584, 16'h0010); apm_wr_en = 0;
      rd_chk("R9 APM over write", 16'hA584, 32'hFFFFFFFF, 32'h0011);
      cfg_wr(8'h5B, 8'h02);
      apm(8'h10);
      chk("R10 smi pulse", 32'(smi), 1);
      step();
      chk("R10 smi one cycle", 32'(smi), 0);
      // R7 timer status drives sci
      io_wr(16'hA582, 16'h0001);
      io_wr(16'hA580, 16'h0001);
      waited = 0;
      while (!sci && waited < 200) begin step(); waited++; end
      chk("R7 tick within period", 32'(waited <= 129), 1);
      rd_chk("R7 timer status", 16'hA580, 32'h0001, 32'h0001);
      // R2 relocation
      cfg_wr(8'h41, 8'h12);
      rd_chk("R2 old base", 16'hA582, 32'hFFFFFFFF, 0);
      rd_chk("R2 new base", 16'h1282, 32'hFFFFFFFF, 32'h0001);
      // R1 reset again
      rst_n = 0; step(); step(); rst_n = 1;
      cfg_wr(8'h80, 8'h01);
      rd_chk("R1 base zero enable", 16'h0002, 32'hFFFFFFFF, 0);
      rd_chk("R1 control after reset", 16'h0004, 32'hFFFFFFFF, 0);
      step();
      done = 1;
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule